// File: doc/BRIEF.md
# Run-Time Reconfigurable PSK Modulator

The modulator turns a serial bit stream into a stream of signed carrier samples. Bits arrive one per accepted handshake and are packed into groups of one, two or three bits. The group size is set by a mode input that selects binary, quaternary or eight-phase keying. Each finished group is turned into one of eight phase points on a 45-degree grid. The two quadrature components of that point each feed a multiplier path against a carrier component, and the difference of the two products is the output sample.

The carrier comes from a phase accumulator that advances by a frequency word once per emitted sample. The top three accumulator bits index the same eight-entry amplitude table that the constellation uses. Each symbol is held on the output for a fixed number of samples. The mode can change while the stream runs, but a new mode only applies from the first bit of the next group. While a finished group waits for the output stage, the input handshake stalls.

Top module: `psk_modulator`

## Requirements
- R1: `mode_sel` = 2'd2 gives 2 bits per symbol, 2'd3 gives 3 bits per symbol, and 2'd1 or 2'd0 gives 1 bit per symbol. The first bit received is the most significant bit of the group.
- R2: A bit is taken only on a clock edge where `bit_valid` and `bit_ready` are both high. Every accepted bit ends up in exactly one symbol.
- R3: Phase point k (0..7) lies at k·45 degrees. Its components are I = C(k) and Q = S(k), where C(k) = round(127·cos) and S(k) = round(127·sin). One-bit groups map bit b to k = 4b. Two-bit groups map 00→0, 01→2, 11→4 and 10→6. Three-bit groups map group g to the k for which g = k XOR (k>>1).
- R4: The mode is sampled together with the first bit of a group. A `mode_sel` change during the later bits of that group has no effect until the next group starts.
- R5: The 16-bit carrier accumulator resets to 0 and adds `freq_word` after each emitted sample. The carrier index is the top 3 bits, giving cos = C(index) and sin = S(index). `freq_word` has no effect on the number of bits per symbol.
- R6: Each symbol yields exactly SPS (default 4) samples on consecutive clocks. If the next group is already complete, its samples follow with no gap.
- R7: Each sample is I·cos − Q·sin of the current carrier index, saturated to a signed 16-bit value.
- R8: After reset `bit_ready` = 1, `samp_valid` = 0 and `samp_data` = 0. `samp_data` is 0 whenever `samp_valid` is low.
- R9: `bit_ready` is low while a completed group waits for the output stage. The waiting group is not changed and no bit is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Input bit present |
| bit_data | input | 1 | Serial input bit |
| bit_ready | output | 1 | Modulator can take a bit |
| mode_sel | input | 2 | Bits per symbol: 1, 2 or 3 (0 acts as 1) |
| freq_word | input | ACC_W (16) | Carrier phase increment per sample |
| samp_valid | output | 1 | Output sample present |
| samp_data | output | 16 | Signed output sample |

## Verification
On every cycle, assertions check the following: the group length stays frozen once a group has begun, the bit count stays below the group length, and a waiting group stays unchanged. They also check that a symbol in progress is never cut short, that the carrier accumulator holds while idle, that samples stay within the product range, and that the output is zeroed when the valid strobe falls. Other behaviours can only be shown by the bench's scenarios. These are the Gray mapping of every group in every mode, mode changes made in the middle of a group, and the carrier rotation under several frequency words. They also include gap-free output across back-to-back symbols, stalling of the input under backpressure, and a total sample count that proves no bit was dropped.

// File: rtl/psk_mod_pkg.sv
package psk_mod_pkg;

    localparam int AMP_W  = 8;
    localparam int PROD_W = 2 * AMP_W;
    localparam int DIFF_W = PROD_W + 1;
    localparam int OUT_W  = 16;
    localparam int PH_W   = 3;
    localparam int GRP_W  = 3;
    localparam int SAT_HI = (2 ** (OUT_W - 1)) - 1;
    localparam int SAT_LO = -(2 ** (OUT_W - 1));

    typedef logic signed [AMP_W-1:0]  amp_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [DIFF_W-1:0] diff_t;
    typedef logic signed [OUT_W-1:0]  out_t;
    typedef logic [PH_W-1:0]          phase_t;

    typedef struct packed {
        logic [1:0]       nbits;
        logic [GRP_W-1:0] grp;
    } sym_t;

    typedef struct packed {
        amp_t i;
        amp_t q;
    } iq_t;

    // Group length for a mode code; unused code 0 behaves as one bit.
    function automatic logic [1:0] bits_of(input logic [1:0] m);
        case (m)
            2'd2:    return 2'd2;
            2'd3:    return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    // Shared eight-step amplitude table, 45 degrees per step.
    function automatic amp_t cos_tab(input phase_t k);
        case (k)
            3'd0:    return  8'sd127;
            3'd1:    return  8'sd90;
            3'd2:    return  8'sd0;
            3'd3:    return -8'sd90;
            3'd4:    return -8'sd127;
            3'd5:    return -8'sd90;
            3'd6:    return  8'sd0;
            default: return  8'sd90;
        endcase
    endfunction

    // sin(x) = cos(x - 90 degrees): two steps back on the same table.
    function automatic amp_t sin_tab(input phase_t k);
        return cos_tab(k - 3'd2);
    endfunction

    // Gray-decoded group to phase step, spread over the circle by mode.
    function automatic phase_t phase_of(input sym_t s);
        logic b2, b1, b0;
        case (s.nbits)
            2'd3: begin
                b2 = s.grp[2];
                b1 = b2 ^ s.grp[1];
                b0 = b1 ^ s.grp[0];
                return {b2, b1, b0};
            end
            2'd2: begin
                b1 = s.grp[1];
                b0 = b1 ^ s.grp[0];
                return {b1, b0, 1'b0};
            end
            default: return {s.grp[0], 2'b00};
        endcase
    endfunction

    function automatic out_t sat_out(input int v);
        if (v > SAT_HI)      return out_t'(SAT_HI);
        else if (v < SAT_LO) return out_t'(SAT_LO);
        else                 return out_t'(v);
    endfunction

endpackage

// File: rtl/psk_bit_gather.sv
module psk_bit_gather
    import psk_mod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_bit,
    input  logic [1:0] mode_in,
    output logic       in_ready,
    output logic       grp_full,
    output sym_t       grp_out,
    input  logic       grp_take
);

    logic [1:0]       cnt;
    logic [1:0]       need;
    logic [GRP_W-1:0] sh;
    logic             full;
    logic             accept;
    logic [1:0]       eff_need;

    assign in_ready = !full;
    assign accept   = in_valid && !full;
    assign eff_need = (cnt == 2'd0) ? bits_of(mode_in) : need;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= 2'd0;
            need <= 2'd1;
            sh   <= '0;
            full <= 1'b0;
        end else begin
            if (grp_take) full <= 1'b0;
            if (accept) begin
                sh <= {sh[GRP_W-2:0], in_bit};
                if (cnt == 2'd0) need <= bits_of(mode_in);
                if (cnt + 2'd1 == eff_need) begin
                    cnt  <= 2'd0;
                    full <= 1'b1;
                end else begin
                    cnt <= cnt + 2'd1;
                end
            end
        end
    end

    assign grp_full      = full;
    assign grp_out.nbits = need;
    assign grp_out.grp   = sh;

    // R4: group length is frozen once the first bit is in
    assert_mode_held_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt != 2'd0) |=> $stable(need));

    // R2: bit count never reaches the group length
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd0) || (cnt < need));

    // R9: a waiting group is left untouched
    assert_group_held_R9: assert property (@(posedge clk) disable iff (rst)
        (full && !grp_take) |=> (full && $stable(sh) && $stable(need)));

endmodule

// File: rtl/psk_symbol_seq.sv
module psk_symbol_seq
    import psk_mod_pkg::*;
#(
    parameter int SPS   = 4,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grp_full,
    input  sym_t             grp_in,
    output logic             grp_take,
    input  logic [ACC_W-1:0] freq,
    output logic             busy,
    output iq_t              iq,
    output phase_t           car_idx
);

    localparam int SPS_W = (SPS > 1) ? $clog2(SPS) : 1;
    localparam logic [SPS_W-1:0] LAST_CNT = SPS_W'(SPS - 1);

    logic [SPS_W-1:0] scnt;
    logic [ACC_W-1:0] acc;
    phase_t           ph;
    logic             last;

    assign last     = busy && (scnt == LAST_CNT);
    assign grp_take = grp_full && (!busy || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            scnt <= '0;
            ph   <= '0;
            acc  <= '0;
        end else begin
            if (busy) acc <= acc + freq;
            if (grp_take) begin
                busy <= 1'b1;
                scnt <= '0;
                ph   <= phase_of(grp_in);
            end else if (last) begin
                busy <= 1'b0;
                scnt <= '0;
            end else if (busy) begin
                scnt <= scnt + 1'b1;
            end
        end
    end

    assign iq.i    = cos_tab(ph);
    assign iq.q    = sin_tab(ph);
    assign car_idx = acc[ACC_W-1 -: PH_W];

    // R6: a symbol is never cut short
    assert_sym_length_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && scnt != LAST_CNT) |=> busy);

    // R5: carrier only advances with emitted samples
    assert_acc_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(acc));

endmodule

// File: rtl/psk_mix_path.sv
module psk_mix_path
    import psk_mod_pkg::*;
(
    input  amp_t  a,
    input  amp_t  b,
    output prod_t p
);

    assign p = a * b;

endmodule

// File: rtl/psk_modulator.sv
module psk_modulator
    import psk_mod_pkg::*;
#(
    parameter int SPS   = 4,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_data,
    output logic             bit_ready,
    input  logic [1:0]       mode_sel,
    input  logic [ACC_W-1:0] freq_word,
    output logic             samp_valid,
    output logic [OUT_W-1:0] samp_data
);

    localparam int NPATH = 2;
    localparam int PEAK  = 2 * 127 * 127;

    logic   grp_full, grp_take, busy;
    sym_t   grp;
    iq_t    iq;
    phase_t car_idx;
    amp_t   op_a [NPATH];
    amp_t   op_b [NPATH];
    prod_t  prod [NPATH];
    diff_t  diff;

    psk_bit_gather u_gather (
        .clk      (clk),
        .rst      (rst),
        .in_valid (bit_valid),
        .in_bit   (bit_data),
        .mode_in  (mode_sel),
        .in_ready (bit_ready),
        .grp_full (grp_full),
        .grp_out  (grp),
        .grp_take (grp_take)
    );

    psk_symbol_seq #(.SPS(SPS), .ACC_W(ACC_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .grp_full (grp_full),
        .grp_in   (grp),
        .grp_take (grp_take),
        .freq     (freq_word),
        .busy     (busy),
        .iq       (iq),
        .car_idx  (car_idx)
    );

    assign op_a[0] = iq.i;
    assign op_b[0] = cos_tab(car_idx);
    assign op_a[1] = iq.q;
    assign op_b[1] = sin_tab(car_idx);

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        psk_mix_path u_mul (
            .a (op_a[g]),
            .b (op_b[g]),
            .p (prod[g])
        );
    end

    assign diff = DIFF_W'(prod[0]) - DIFF_W'(prod[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_valid <= 1'b0;
            samp_data  <= '0;
        end else begin
            samp_valid <= busy;
            samp_data  <= busy ? sat_out(int'(diff)) : '0;
        end
    end

    // R7: samples stay inside the reachable product range
    assert_sample_bound_R7: assert property (@(posedge clk) disable iff (rst)
        samp_valid |-> ($signed(samp_data) <= PEAK && $signed(samp_data) >= -PEAK));

    // R8: output returns to zero when the stream stops
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(samp_valid) |-> (samp_data == '0));

endmodule

// File: tb/test_psk_modulator.sv
module test_psk_modulator;

    localparam int SPS   = 4;
    localparam int NVEC  = 15;
    localparam int MAXS  = 256;

    // fields: [9:8] mode, [7:6] mode driven on later bits, [5:3] group, [2:0] expected phase
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd1, 2'd3, 3'b000, 3'd0},
        {2'd1, 2'd2, 3'b001, 3'd4},
        {2'd0, 2'd3, 3'b001, 3'd4},
        {2'd2, 2'd3, 3'b000, 3'd0},
        {2'd2, 2'd1, 3'b001, 3'd2},
        {2'd2, 2'd3, 3'b011, 3'd4},
        {2'd2, 2'd1, 3'b010, 3'd6},
        {2'd3, 2'd1, 3'b000, 3'd0},
        {2'd3, 2'd2, 3'b001, 3'd1},
        {2'd3, 2'd1, 3'b011, 3'd2},
        {2'd3, 2'd2, 3'b010, 3'd3},
        {2'd3, 2'd1, 3'b110, 3'd4},
        {2'd3, 2'd2, 3'b111, 3'd5},
        {2'd3, 2'd1, 3'b101, 3'd6},
        {2'd3, 2'd2, 3'b100, 3'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_data = 1'b0;
    logic        bit_ready;
    logic [1:0]  mode_sel = 2'd1;
    logic [15:0] freq_word = 16'h0000;
    logic        samp_valid;
    logic [15:0] samp_data;

    int checks = 0;
    int fails  = 0;
    int nsent  = 0;
    int nsamp  = 0;
    int model_acc = 0;
    int exp_ph [MAXS];
    bit prev_valid = 1'b0;
    bit saw_block  = 1'b0;
    bit done       = 1'b0;

    always #4 clk = ~clk;

    psk_modulator #(.SPS(SPS), .ACC_W(16)) i_psk_modulator (
        .clk        (clk),
        .rst        (rst),
        .bit_valid  (bit_valid),
        .bit_data   (bit_data),
        .bit_ready  (bit_ready),
        .mode_sel   (mode_sel),
        .freq_word  (freq_word),
        .samp_valid (samp_valid),
        .samp_data  (samp_data)
    );

    function automatic int rnd127(input real x);
        real y;
        y = 127.0 * x;
        if (y >= 0.0) return $rtoi(y + 0.5);
        else          return -$rtoi(-y + 0.5);
    endfunction

    function automatic int cv(input int k);
        return rnd127($cos(3.14159265358979 * k / 4.0));
    endfunction

    function automatic int sv(input int k);
        return rnd127($sin(3.14159265358979 * k / 4.0));
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    // Sample monitor: expected value from the phase list and a carrier model.
    always @(negedge clk) begin
        if (rst) begin
            prev_valid = 1'b0;
        end else begin
            if (samp_valid) begin : mon
                int s_in, sidx, k, ph, e, got;
                s_in = nsamp % SPS;
                sidx = nsamp / SPS;
                k    = (model_acc >> 13) & 7;
                ph   = exp_ph[sidx % MAXS];
                e    = cv(ph) * cv(k) - sv(ph) * sv(k);
                got  = int'($signed(samp_data));
                // R1 R3 R4 R7: group size, Gray mapping, held mode, mixing
                check(got == e, "R1/R3/R4/R7 sample", got, e);
                if (s_in != 0) check(prev_valid, "R6 gap inside symbol", 0, 1);
                model_acc = (model_acc + int'(freq_word)) & 16'hFFFF;
                nsamp++;
            end
            if (bit_valid && !bit_ready) saw_block = 1'b1;
            prev_valid = samp_valid;
        end
    end

    task automatic send_bit(input logic b, input logic [1:0] m);
        bit_valid = 1'b1;
        bit_data  = b;
        mode_sel  = m;
        while (!bit_ready) @(negedge clk);
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_vec(input logic [9:0] v);
        int n;
        n = (v[9:8] == 2'd3) ? 3 : (v[9:8] == 2'd2) ? 2 : 1;
        exp_ph[nsent % MAXS] = int'(v[2:0]);
        nsent++;
        for (int i = n - 1; i >= 0; i--)
            send_bit(v[3 + i], (i == n - 1) ? v[9:8] : v[7:6]);
    endtask

    task automatic drain();
        while (nsamp < nsent * SPS) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check(bit_ready == 1'b1, "R8 ready after reset", int'(bit_ready), 1);
        check(samp_valid == 1'b0, "R8 valid after reset", int'(samp_valid), 0);
        check(samp_data == 16'h0, "R8 data after reset", int'(samp_data), 0);

        // table walk at three carrier rates; freq changes only while idle (R5)
        for (int pass = 0; pass < 3; pass++) begin
            freq_word = (pass == 0) ? 16'h0000 : (pass == 1) ? 16'h2000 : 16'h0C00;
            for (int v = 0; v < NVEC; v++) send_vec(VEC[v]);
            drain();
            check(samp_valid == 1'b0 && samp_data == 16'h0, "R8 idle output zero",
                  int'(samp_data), 0);
        end

        // back-to-back single-bit groups force backpressure and gap-free output
        freq_word = 16'h2000;
        for (int r = 0; r < 8; r++) send_vec(VEC[r % 3]);
        drain();
        check(saw_block, "R9 ready held low while group waits", int'(saw_block), 1);
        // R2 R5: every bit landed in a symbol at every carrier rate
        check(nsamp == nsent * SPS, "R2/R5 total samples", nsamp, nsent * SPS);
        check(bit_ready == 1'b1, "R9 ready back after drain", int'(bit_ready), 1);
        finish_run();
    end

endmodule